// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is the software-visible register file of a four-channel co-processor. It sits on a simple 32-bit read/write bus. It holds three registers: a global control word, a global status word and a channel control word. The control fields drive soft reset, clock gating, interrupt enables and channel enables straight into the rest of the engine.

Each register answers at four word addresses. The first replaces the register contents. The other three OR the written data in, clear the bits written as 1, or invert the bits written as 1. Software can therefore change one bit without a read-modify-write sequence. Per-channel completion pulses are caught in sticky status flags. Software removes a flag through the clear alias of the status register. The flags, masked by the enables in the control word, form a single interrupt line.

Top module: `csr_alias_bank`

## Requirements
- R1: After reset, soft_rst_o and clk_gate_o are 1, all other control and channel fields are 0, and the status flags are 0.
- R2: A write with req_i and we_i to a register base address (address bits [3:2] = 0) replaces its writable bits at the next clock edge. The control register is at 0x000 with writable bits 31 (soft reset), 30 (clock gate), 23 (gather write), 22 (context cache), 21 (context switch) and 3:0 (interrupt enables for channels 0..3). The channel register is at 0x020 with writable bits 16 (channel 0 interrupt merge), 11:8 (high priority) and 3:0 (channel enable). Each field appears on its output port.
- R3: A write at base+0x4 ORs the data into the writable bits.
- R4: A write at base+0x8 clears the writable bits that are written as 1.
- R5: A write at base+0xC inverts the writable bits that are written as 1.
- R6: Control bit 29 reads the cipher-present parameter and bit 28 reads the hash-present parameter. Writes cannot change them. Bits of any register that have no field read as 0.
- R7: The status register at 0x010 reads the flags on [3:0], ch_ready_i on [19:16], ch_active_i on [27:24] and key_ready_i on [28]. The input bits are visible in the same cycle.
- R8: A one-cycle pulse on ch_irq_i[n] sets flag n from the next cycle on. The flag stays set until a write to 0x018 with bit n set. Writes to 0x010, 0x014 and 0x01C leave the flags unchanged. A pulse in the same cycle as its clear leaves the flag set.
- R9: irq_o is 1 exactly when some flag n and control bit n are both 1.
- R10: While soft_rst_o is 1, each clock edge returns the channel register and the flags to 0. Pulses and channel register writes in that cycle are lost.
- R11: Any register index above 2 (address 0x030 and up) reads 0 and writes to it change nothing. Reads at an alias address return the register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| addr_i | input | ADDR_W | Byte address, bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ch_irq_i | input | 4 | Per-channel completion pulses |
| ch_ready_i | input | 4 | Per-channel ready state |
| ch_active_i | input | 4 | Channel currently active |
| key_ready_i | input | 1 | Fused key available |
| soft_rst_o | output | 1 | Soft reset to the engine |
| clk_gate_o | output | 1 | Clock gate request |
| ch_irq_en_o | output | 4 | Per-channel interrupt enables |
| ctx_switch_en_o | output | 1 | Context switching enable |
| ctx_cache_en_o | output | 1 | Context cache enable |
| gather_wr_en_o | output | 1 | Gather result write enable |
| ch_en_o | output | 4 | Channel enables |
| ch_high_prio_o | output | 4 | Channel high priority marks |
| ch0_irq_merge_o | output | 1 | Merge channel 0 interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
Reads are combinational. The bench sets the address and compares rdata_o within the same low clock phase, before any edge. Writes, pulses and soft-reset holds take effect at the single edge they span. The bench drives each one for one cycle from a falling edge and updates its model only once that edge has passed. It samples the field outputs and irq_o at the next falling edge, which is one cycle after the stimulus. Status input bits are checked in the same cycle they are driven.

// File: rtl/csr_alias_pkg.sv
`timescale 1ns/1ps
package csr_alias_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned NUM_REGS = 3;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_CHAN = 2;

  localparam logic [31:0] CTRL_WMASK = 32'hC0E0_000F;
  localparam logic [31:0] CTRL_RST   = 32'hC000_0000;
  localparam logic [31:0] CHAN_WMASK = 32'h0001_0F0F;
  localparam logic [31:0] CHAN_RST   = 32'h0000_0000;

  function automatic logic [31:0] alias_apply(alias_op_e op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return cur | wd;
      OP_CLR:   return cur & ~wd;
      default:  return cur ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/csr_alias_decode.sv
`timescale 1ns/1ps
module csr_alias_decode
  import csr_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output alias_op_e         op_o
);
  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;

  assign idx        = addr_i[ADDR_W-1:4];
  assign op_o       = alias_op_e'(addr_i[3:2]);
  assign unused_lsb = ^addr_i[1:0];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel_o[r] = req_i && we_i && (idx == IDX_W'(r));
  end
endmodule

// File: rtl/csr_alias_reg.sv
`timescale 1ns/1ps
module csr_alias_reg
  import csr_alias_pkg::*;
#(
  parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
  parameter logic [31:0] RST   = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  alias_op_e   op_i,
  input  logic [31:0] wdata_i,
  input  logic        hold_i,
  output logic [31:0] q_o
);
  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST & WMASK;
    else if (hold_i) q <= RST & WMASK;
    else if (wr_i)   q <= alias_apply(op_i, q, wdata_i) & WMASK;
  end

  assign q_o = q;
endmodule

// File: rtl/csr_irq_flags.sv
`timescale 1ns/1ps
module csr_irq_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic [NCH-1:0] pulse_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] clr_mask_i,
  output logic [NCH-1:0] flags_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_flag
    logic f;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     f <= 1'b0;
      else if (hold_i) f <= 1'b0;
      else             f <= (f && !(clr_i && clr_mask_i[n])) || pulse_i[n]; // set wins
    end
    assign flags_o[n] = f;
  end
endmodule

// File: rtl/csr_alias_bank.sv
`timescale 1ns/1ps
module csr_alias_bank
  import csr_alias_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [3:0]        ch_irq_i,
  input  logic [3:0]        ch_ready_i,
  input  logic [3:0]        ch_active_i,
  input  logic              key_ready_i,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic [3:0]        ch_irq_en_o,
  output logic              ctx_switch_en_o,
  output logic              ctx_cache_en_o,
  output logic              gather_wr_en_o,
  output logic [3:0]        ch_en_o,
  output logic [3:0]        ch_high_prio_o,
  output logic              ch0_irq_merge_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 4;
  localparam logic [31:0] CAP_BITS = {2'b00, HAS_CIPHER, HAS_HASH, 28'h0};

  logic [NUM_REGS-1:0] wr_sel;
  alias_op_e           op;
  logic [31:0]         ctrl_q, chan_q;
  logic [NUM_CH-1:0]   flags;
  logic [IDX_W-1:0]    rd_idx;

  csr_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .op_o     (op)
  );

  csr_alias_reg #(.WMASK(CTRL_WMASK), .RST(CTRL_RST)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel[REG_CTRL]),
    .op_i    (op),
    .wdata_i (wdata_i),
    .hold_i  (1'b0),
    .q_o     (ctrl_q)
  );

  csr_alias_reg #(.WMASK(CHAN_WMASK), .RST(CHAN_RST)) u_chan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel[REG_CHAN]),
    .op_i    (op),
    .wdata_i (wdata_i),
    .hold_i  (ctrl_q[31]),
    .q_o     (chan_q)
  );

  csr_irq_flags #(.NCH(NUM_CH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (ctrl_q[31]),
    .pulse_i    (ch_irq_i),
    .clr_i      (wr_sel[REG_STAT] && op == OP_CLR),
    .clr_mask_i (wdata_i[NUM_CH-1:0]),
    .flags_o    (flags)
  );

  assign rd_idx = addr_i[ADDR_W-1:4];

  always_comb begin
    rdata_o = 32'h0;
    if (rd_idx == IDX_W'(REG_CTRL))
      rdata_o = ctrl_q | CAP_BITS;
    else if (rd_idx == IDX_W'(REG_STAT))
      rdata_o = {3'b000, key_ready_i, ch_active_i, 4'h0, ch_ready_i, 12'h000, flags};
    else if (rd_idx == IDX_W'(REG_CHAN))
      rdata_o = chan_q;
  end

  assign soft_rst_o      = ctrl_q[31];
  assign clk_gate_o      = ctrl_q[30];
  assign gather_wr_en_o  = ctrl_q[23];
  assign ctx_cache_en_o  = ctrl_q[22];
  assign ctx_switch_en_o = ctrl_q[21];
  assign ch_irq_en_o     = ctrl_q[3:0];
  assign ch0_irq_merge_o = chan_q[16];
  assign ch_high_prio_o  = chan_q[11:8];
  assign ch_en_o         = chan_q[3:0];
  assign irq_o           = |(flags & ctrl_q[3:0]);
endmodule

// File: rtl/csr_alias_bank_chk.sv
`timescale 1ns/1ps
module csr_alias_bank_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [3:0]        ch_irq_i,
  input logic [31:0]       rdata_o,
  input logic              soft_rst_o,
  input logic [3:0]        ch_irq_en_o,
  input logic [3:0]        ch_en_o,
  input logic [3:0]        ch_high_prio_o,
  input logic              irq_o
);
  logic wr;
  assign wr = req_i && we_i;

  p_set_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(32'h004)) |=>
      ((ch_irq_en_o & $past(wdata_i[3:0])) == $past(wdata_i[3:0])));

  p_clr_alias_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(32'h008)) |=> ((ch_irq_en_o & $past(wdata_i[3:0])) == 4'h0));

  p_tog_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(32'h00C)) |=>
      (ch_irq_en_o == ($past(ch_irq_en_o) ^ $past(wdata_i[3:0]))));

  p_irq_raise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_irq_i[0] && !soft_rst_o && ch_irq_en_o[0] && !wr) |=> irq_o);

  p_soft_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (ch_en_o == 4'h0 && ch_high_prio_o == 4'h0));

  p_unmapped_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:4] > (ADDR_W-4)'(2)) |-> (rdata_o == 32'h0));
endmodule

bind csr_alias_bank csr_alias_bank_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_csr_alias_bank.sv
`timescale 1ns/1ps
module test_csr_alias_bank;
  localparam logic [31:0] CMASK = 32'hC0E0_000F;
  localparam logic [31:0] HMASK = 32'h0001_0F0F;
  localparam logic [31:0] CAPS  = 32'h3000_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0, key_ready_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [3:0]  ch_irq_i = '0, ch_ready_i = '0, ch_active_i = '0;
  logic soft_rst_o, clk_gate_o, ctx_switch_en_o, ctx_cache_en_o, gather_wr_en_o, ch0_irq_merge_o, irq_o;
  logic [3:0] ch_irq_en_o, ch_en_o, ch_high_prio_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] ctrl_m = 32'hC000_0000, chan_m = '0;
  logic [3:0]  flag_m = '0;

  always #4 clk_i = ~clk_i;

  csr_alias_bank i_csr_alias_bank (.*);

  function automatic logic [31:0] f_apply(logic [1:0] op, logic [31:0] cur, logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return cur | d;
      2'd2: return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus: optional write plus channel pulses
  task automatic cyc(logic wr, logic [11:0] a, logic [31:0] d, logic [3:0] pulse);
    logic hold;
    logic [1:0] op;
    @(negedge clk_i);
    req_i = wr; we_i = wr; addr_i = a; wdata_i = d; ch_irq_i = pulse;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; ch_irq_i = '0;
    hold = ctrl_m[31];
    op = a[3:2];
    if (wr && a[11:4] == 8'd0) ctrl_m = f_apply(op, ctrl_m, d) & CMASK;
    if (hold) begin
      chan_m = '0; flag_m = '0;
    end else begin
      if (wr && a[11:4] == 8'd2) chan_m = f_apply(op, chan_m, d) & HMASK;
      if (wr && a[11:4] == 8'd1 && op == 2'd2) flag_m = flag_m & ~d[3:0];
      flag_m = flag_m | pulse;
    end
  endtask

  task automatic check_all(string tag);
    addr_i = 12'h000; #1 check({tag, " R6 ctrl read"}, rdata_o, ctrl_m | CAPS);
    addr_i = 12'h010; #1 check({tag, " R7 stat read"}, rdata_o,
      {3'b0, key_ready_i, ch_active_i, 4'h0, ch_ready_i, 12'h0, flag_m});
    addr_i = 12'h020; #1 check({tag, " R2 chan read"}, rdata_o, chan_m);
    check({tag, " R2 ctrl ports"}, {26'h0, soft_rst_o, clk_gate_o, gather_wr_en_o, ctx_cache_en_o, ctx_switch_en_o, 1'b0},
      {26'h0, ctrl_m[31], ctrl_m[30], ctrl_m[23], ctrl_m[22], ctrl_m[21], 1'b0});
    check({tag, " R2 ch_irq_en"}, {28'h0, ch_irq_en_o}, {28'h0, ctrl_m[3:0]});
    check({tag, " R2 chan ports"}, {15'h0, ch0_irq_merge_o, 4'h0, ch_high_prio_o, 4'h0, ch_en_o}, chan_m);
    check({tag, " R9 irq"}, {31'h0, irq_o}, {31'h0, |(flag_m & ctrl_m[3:0])});
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 reset");
    check("R1 soft_rst", {31'h0, soft_rst_o}, 32'h1);
    check("R1 clk_gate", {31'h0, clk_gate_o}, 32'h1);

    // R10: channel writes and pulses lost while soft reset is set
    cyc(1'b1, 12'h020, 32'hFFFF_FFFF, 4'hF);
    check_all("R10 hold");
    check("R10 chan zero", {28'h0, ch_en_o}, 32'h0);

    // R2 plain write clears soft reset and clock gate
    cyc(1'b1, 12'h000, 32'hFFFF_FFFF, 4'h0);
    check_all("R2 ctrl full");
    cyc(1'b1, 12'h000, 32'h0000_000A, 4'h0);
    check_all("R2 ctrl plain");
    check("R6 caps write", ctrl_m | CAPS, 32'h3000_000A);
    cyc(1'b1, 12'h020, 32'hFFFF_FFFF, 4'h0);
    check_all("R2 chan plain");
    check("R2 chan mask", chan_m, 32'h0001_0F0F);
    cyc(1'b1, 12'h024, 32'h0000_0000, 4'h0);
    cyc(1'b1, 12'h028, 32'h0000_0105, 4'h0);
    check_all("R4 chan clr");
    cyc(1'b1, 12'h004, 32'h0000_0005, 4'h0);
    check_all("R3 ctrl set");
    cyc(1'b1, 12'h00C, 32'h0060_0003, 4'h0);
    check_all("R5 ctrl tog");

    // R8: sticky flags, ignored writes, set-over-clear
    cyc(1'b0, 12'h000, 32'h0, 4'b0110);
    check_all("R8 pulse");
    cyc(1'b0, 12'h000, 32'h0, 4'b0000);
    check_all("R8 sticky");
    cyc(1'b1, 12'h010, 32'h0000_0000, 4'h0);
    cyc(1'b1, 12'h014, 32'h0000_000F, 4'h0);
    cyc(1'b1, 12'h01C, 32'h0000_000F, 4'h0);
    check_all("R8 other aliases");
    check("R8 flags kept", {28'h0, flag_m}, 32'h6);
    cyc(1'b1, 12'h018, 32'h0000_0006, 4'b0100);
    check_all("R8 set wins");
    check("R8 coincident", {28'h0, flag_m}, 32'h4);

    // R11: unmapped and alias reads
    addr_i = 12'h030; #1 check("R11 unmapped 030", rdata_o, 32'h0);
    addr_i = 12'hFF4; #1 check("R11 unmapped FF4", rdata_o, 32'h0);
    addr_i = 12'h02C; #1 check("R11 alias read", rdata_o, chan_m);
    cyc(1'b1, 12'h030, 32'hFFFF_FFFF, 4'h0);
    cyc(1'b1, 12'h03C, 32'hFFFF_FFFF, 4'h0);
    check_all("R11 unmapped write");

    // R7: live status inputs
    ch_ready_i = 4'h9; ch_active_i = 4'h2; key_ready_i = 1'b1;
    check_all("R7 live");

    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [11:0] a;
      kind = int'($urandom % 5);
      ch_ready_i = 4'($urandom); ch_active_i = 4'($urandom); key_ready_i = 1'($urandom);
      d = $urandom;
      if (($urandom % 4) != 0) d[31] = 1'b0;
      a = {8'($urandom % 4), 2'($urandom), 2'b00};
      if (kind == 0) cyc(1'b0, 12'h0, 32'h0, 4'($urandom));
      else if (kind == 1) cyc(1'b1, a, d, 4'($urandom));
      else cyc(1'b1, a, d, 4'h0);
      check_all("R3 R4 R5 R8 R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule